// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master

This block is a serial master that moves one word at a time over a single shared data line. It produces the serial clock itself, dividing the system clock by a power of two picked with a 3-bit code. It also drives one of two active-low chip enables for the addressed slave. The host sets up the transfer on a set of control inputs and pulses `start`. The configuration is captured at that moment and holds for the whole transfer.

The shared data line is presented as three signals for an external pad: an output value, an output enable and an input value. In write direction the block drives the line and also samples it back. In read direction it releases the line and collects what the slave drives. The words move MSB first and are 8 or 16 bits long. One control bit sets which serial-clock edge changes the data and which edge samples it. `busy` is high while a transfer runs, and a one-cycle `done` pulse marks the end.

Top module: `ssp_master`

## Requirements
- R1: After reset, `ce_n` is all ones, `busy`, `done` and `sdat_oe` are 0, and `sclk` is 1.
- R2: With division code n on `div_code`, the serial clock period is 2^(n+1) system clocks, so half a period is 2^n clocks. Codes 000, 001 and 010 give 2, 4 and 8. Code 011 gives 16, 100 gives 32, 101 gives 64, 110 gives 128 and 111 gives 256.
- R3: With `edge_sel`=1, `sclk` idles low, data changes on its rising edges and is sampled on its falling edges. With `edge_sel`=0, `sclk` idles high, data changes on falling edges and is sampled on rising edges. While no transfer runs, `sclk` follows the idle level of the current `edge_sel` one clock later.
- R4: On an accepted start, only `ce_n[ce_sel]` goes low, in the cycle after the start edge. That is exactly one half period before the first data-change edge. The other enables stay high.
- R5: Words go out MSB first. With `long_word`=1, all 16 bits of `tx_word` are sent. With `long_word`=0, only `tx_word[7:0]` is sent, as 8 bits.
- R6: With `dir_write`=1, `sdat_oe` is 1 from the cycle after the start edge until the end of the transfer. With `dir_write`=0, `sdat_oe` stays 0. `sdat_oe` is 0 whenever `busy` is 0.
- R7: At each sampling edge, the value on `sdat_i` is shifted into `rx_word` from the LSB end. This leaves the first received bit as the most significant received bit. In 8-bit mode, `rx_word[15:8]` reads 0. At `done`, `rx_word` holds the complete received word.
- R8: `busy` rises in the cycle after the start edge. One half period after the last sampling edge, three things happen in the same cycle: `busy` falls, every `ce_n` goes high and `done` pulses high for exactly one cycle. At that point `sclk` is at its idle level.
- R9: A `start` pulse while `busy` is 1 is ignored. The running word, chip enable and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| tx_word | input | 16 | Word to send |
| div_code | input | 3 | Serial clock division code |
| edge_sel | input | 1 | 1: change on rising / sample on falling; 0: the reverse |
| long_word | input | 1 | 1: 16-bit word, 0: 8-bit word |
| dir_write | input | 1 | 1: drive the data line, 0: release it |
| ce_sel | input | 1 | Index of the chip enable to assert |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 16 | Sampled word, right-justified |
| sclk | output | 1 | Serial clock |
| ce_n | output | 2 | Active-low chip enables |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The bench times the serial clock against the system clock at the slowest codes, at the fastest code and at the middle codes. A divider that is off by one cycle, or that decodes the code wrongly, shows up as a wrong half-period or full-period count. Both edge settings are run in both directions. A design that swapped the change and sample edges would read the slave's bits half a period early and return a corrupted word. The 8-bit case sends a `tx_word` with a non-zero upper byte, so a design that sent the wrong byte or left stale upper bits in `rx_word` miscompares. A second `start` with a different word and enable is issued mid-transfer. A design that restarted on it would drop the wrong enable or send the new word.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   // Number of system clocks in one serial half period for a division code.
   function automatic int unsigned half_clocks(input int unsigned code);
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
   parameter int CODE_W = 3,
   localparam int CNT_W = (1 << CODE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   // limit = half period - 1 = 2^code - 1
   always_comb begin
      lim = '0;
      for (int b = 0; b < CNT_W; b++) begin
         if (b < int'(code)) lim[b] = 1'b1;
      end
   end

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int MAX_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             long_word,
   input  logic [MAX_W-1:0] tx_word,
   input  logic             shift_en,
   input  logic             sample_en,
   input  logic             pin_in,
   output logic             out_bit,
   output logic [MAX_W-1:0] rx_word
);
   logic [MAX_W-1:0] tx_sr;
   logic [MAX_W-1:0] rx_sr;
   logic [MAX_W-1:0] tx_aligned;

   // left-justify the word so the MSB of either length leaves first
   assign tx_aligned = long_word ? tx_word
                                 : {tx_word[SHORT_W-1:0], {(MAX_W-SHORT_W){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         out_bit <= 1'b0;
      end else if (load) begin
         tx_sr   <= tx_aligned;
         rx_sr   <= '0;
         out_bit <= 1'b0;
      end else begin
         if (shift_en) begin
            out_bit <= tx_sr[MAX_W-1];
            tx_sr   <= {tx_sr[MAX_W-2:0], 1'b0};
         end
         if (sample_en) begin
            rx_sr <= {rx_sr[MAX_W-2:0], pin_in};
         end
      end
   end

   assign rx_word = rx_sr;
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
   parameter int MAX_W   = 16,
   parameter int SHORT_W = 8,
   localparam int STEP_W = $clog2(2 * MAX_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_q,
   input  logic tick,
   output logic load,
   output logic shift_en,
   output logic sample_en,
   output logic finish,
   output logic busy,
   output logic done
);
   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] total;

   assign total     = long_q ? STEP_W'(2 * MAX_W) : STEP_W'(2 * SHORT_W);
   assign load      = start && !busy;
   // tick with even step: change edge; odd step: sample edge; step == total: release
   assign shift_en  = busy && tick && (step < total) && !step[0];
   assign sample_en = busy && tick && (step < total) &&  step[0];
   assign finish    = busy && tick && (step == total);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else begin
         done <= finish;
         if (load) begin
            busy <= 1'b1;
            step <= '0;
         end else if (finish) begin
            busy <= 1'b0;
         end else if (busy && tick) begin
            step <= step + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssp_master.sv
module ssp_master #(
   parameter int MAX_W   = 16,
   parameter int SHORT_W = 8,
   parameter int CODE_W  = 3,
   parameter int NUM_CE  = 2,
   localparam int SEL_W  = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MAX_W-1:0]  tx_word,
   input  logic [CODE_W-1:0] div_code,
   input  logic              edge_sel,
   input  logic              long_word,
   input  logic              dir_write,
   input  logic [SEL_W-1:0]  ce_sel,
   output logic              busy,
   output logic              done,
   output logic [MAX_W-1:0]  rx_word,
   output logic              sclk,
   output logic [NUM_CE-1:0] ce_n,
   output logic              sdat_o,
   output logic              sdat_oe,
   input  logic              sdat_i
);
   initial begin
      assert (SHORT_W > 1 && SHORT_W < MAX_W) else $error("SHORT_W must lie in 2..MAX_W-1");
      assert (CODE_W >= 1 && CODE_W <= 4) else $error("CODE_W must lie in 1..4");
      assert (NUM_CE >= 1) else $error("NUM_CE must be at least 1");
   end

   logic              load, shift_en, sample_en, finish, tick;
   logic              long_q, dir_q, idle_q;
   logic [CODE_W-1:0] code_q;

   // configuration captured at an accepted start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         long_q <= 1'b0;
         dir_q  <= 1'b0;
         idle_q <= 1'b1;
         code_q <= '0;
      end else if (load) begin
         long_q <= long_word;
         dir_q  <= dir_write;
         idle_q <= ~edge_sel;
         code_q <= div_code;
      end
   end

   ssp_ctrl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .long_q(long_q), .tick(tick),
      .load(load), .shift_en(shift_en), .sample_en(sample_en), .finish(finish),
      .busy(busy), .done(done)
   );

   ssp_clkgen #(.CODE_W(CODE_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .code(code_q), .tick(tick)
   );

   ssp_shifter #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .long_word(long_word),
      .tx_word(tx_word), .shift_en(shift_en), .sample_en(sample_en),
      .pin_in(sdat_i), .out_bit(sdat_o), .rx_word(rx_word)
   );

   // serial clock: idle level when idle, leaves idle on change edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sclk <= 1'b1;
      else if (!busy)      sclk <= ~edge_sel;
      else if (shift_en)   sclk <= ~idle_q;
      else if (sample_en)  sclk <= idle_q;
   end

   // data line drive enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sdat_oe <= 1'b0;
      else if (load)    sdat_oe <= dir_write;
      else if (finish)  sdat_oe <= 1'b0;
   end

   // one chip enable flop per slave
   for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ce_n[i] <= 1'b1;
         else if (load)    ce_n[i] <= (ce_sel != SEL_W'(i));
         else if (finish)  ce_n[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk #(
   parameter int NUM_CE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [NUM_CE-1:0] ce_n,
   input logic              sclk,
   input logic              sdat_oe,
   input logic              idle_q
);
   // R4: never more than one chip enable low
   a_r4_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n));

   // R4: a chip enable is low only during a transfer
   a_r4_ce_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n != {NUM_CE{1'b1}}) |-> busy);

   // R8: done lasts exactly one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done coincides with the fall of busy
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: enables released together with done
   a_r8_ce_released: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ce_n == {NUM_CE{1'b1}}));

   // R3: serial clock rests at its idle level when the transfer ends
   a_r3_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sclk == idle_q));

   // R6: data line driven only while busy
   a_r6_oe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sdat_oe |-> busy);

   // R9: captured idle level unchanged throughout a transfer
   a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(idle_q));
endmodule

bind ssp_master ssp_master_chk #(.NUM_CE(NUM_CE)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ce_n(ce_n),
   .sclk(sclk), .sdat_oe(sdat_oe), .idle_q(idle_q)
);

// File: tb/ssp_master_tb_top.sv
module ssp_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] tx_word = '0;
   logic [2:0]  div_code = '0;
   logic        edge_sel = 1'b0;
   logic        long_word = 1'b0;
   logic        dir_write = 1'b0;
   logic        ce_sel = 1'b0;
   logic        busy, done, sclk, sdat_o, sdat_oe;
   logic [15:0] rx_word;
   logic [1:0]  ce_n;
   logic        slave_val = 1'b0;
   logic        pin;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   assign pin = sdat_oe ? sdat_o : slave_val;

   ssp_master dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .div_code(div_code), .edge_sel(edge_sel), .long_word(long_word),
      .dir_write(dir_write), .ce_sel(ce_sel), .busy(busy), .done(done),
      .rx_word(rx_word), .sclk(sclk), .ce_n(ce_n), .sdat_o(sdat_o),
      .sdat_oe(sdat_oe), .sdat_i(pin)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_change(input bit es);
      if (es) @(posedge sclk); else @(negedge sclk);
   endtask

   task automatic wait_sample(input bit es);
      if (es) @(negedge sclk); else @(posedge sclk);
   endtask

   // one full transfer, checked bit by bit
   task automatic run_xfer(input logic [2:0] code, input bit es, input bit lw,
                           input bit wr, input bit sel, input logic [15:0] word,
                           input bit poke);
      int          nb = lw ? 16 : 8;
      longint      half = longint'(1) << code;
      logic [15:0] eff = lw ? word : {8'h00, word[7:0]};
      time         t_start, t_prev, t_now, t_last;
      @(negedge clk);
      tx_word = word; div_code = code; edge_sel = es; long_word = lw;
      dir_write = wr; ce_sel = sel; start = 1'b1;
      @(posedge clk);
      t_start = $time;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", busy, 1);
      chk(ce_n == (sel ? 2'b01 : 2'b10), "R4 chip enable select", ce_n, sel ? 1 : 2);
      chk(sdat_oe == wr, "R6 drive enable", sdat_oe, wr);
      t_prev = 0;
      t_last = 0;
      for (int i = 0; i < nb; i++) begin
         wait_change(es);
         t_now = $time;
         if (i == 0)
            chk((t_now - t_start) == half * CLK_PERIOD, "R4 lead of enable",
                (t_now - t_start) / CLK_PERIOD, half);
         else if (i == 1)
            chk((t_now - t_prev) == 2 * half * CLK_PERIOD, "R2 serial period",
                (t_now - t_prev) / CLK_PERIOD, 2 * half);
         t_prev = t_now;
         if (!wr) begin
            #1 slave_val = eff[nb-1-i];
         end
         wait_sample(es);
         t_last = $time;
         chk(($time - t_now) == half * CLK_PERIOD, "R3 sample edge half period later",
             ($time - t_now) / CLK_PERIOD, half);
         if (wr)
            chk(sdat_o == eff[nb-1-i] && sdat_oe, "R5 bit order", sdat_o, eff[nb-1-i]);
         else
            chk(sdat_oe == 1'b0, "R6 released in read", sdat_oe, 0);
         if (poke && i == 0) begin
            @(negedge clk);
            tx_word = ~word; ce_sel = ~sel; long_word = ~lw; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(ce_n == (sel ? 2'b01 : 2'b10) && busy, "R9 start ignored", ce_n, sel ? 1 : 2);
         end
      end
      @(posedge done);
      chk(($time - t_last) == half * CLK_PERIOD, "R8 release one half later",
          ($time - t_last) / CLK_PERIOD, half);
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R8 done and busy", {done, busy}, 2);
      chk(ce_n == 2'b11, "R8 enables released", ce_n, 3);
      chk(sclk == ~es, "R3 idle level at end", sclk, ~es);
      chk(sdat_oe == 1'b0, "R6 released at end", sdat_oe, 0);
      chk(rx_word == eff, "R7 received word", rx_word, eff);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
   endtask

   task automatic test_reset();
      chk(ce_n == 2'b11, "R1 enables", ce_n, 3);
      chk(busy == 1'b0 && done == 1'b0, "R1 busy done", {busy, done}, 0);
      chk(sclk == 1'b1, "R1 sclk", sclk, 1);
      chk(sdat_oe == 1'b0, "R1 oe", sdat_oe, 0);
   endtask

   task automatic test_idle_follow();
      @(negedge clk); edge_sel = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0, "R3 idle follows edge_sel=1", sclk, 0);
      edge_sel = 1'b0;
      @(negedge clk);
      chk(sclk == 1'b1, "R3 idle follows edge_sel=0", sclk, 1);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            summary();
         end
      end
   end

   initial begin
      #(3 * CLK_PERIOD + 2);
      test_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_idle_follow();
      run_xfer(3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 16'hA5C3, 1'b0);
      run_xfer(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 16'h3C5A, 1'b0);
      run_xfer(3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 16'h9E31, 1'b0);
      run_xfer(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h77C6, 1'b0);
      run_xfer(3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0096, 1'b1);
      run_xfer(3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8001, 1'b0);
      run_xfer(3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 16'h004B, 1'b0);
      summary();
   end
endmodule